// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Selectable Store Policies

This block sits between a processor's load/store port and a slower memory that moves whole lines. It keeps 32 lines of 32 bytes each (1 KB) for a 32-bit byte address space. Every line carries a tag, a valid bit and a dirty bit. Loads and stores can be a byte, a halfword or a word, and each is marked with a 4-bit byte-enable.

Two parameters set the store behaviour, and each can be chosen without the other:
- `WRITE_BACK` picks write-back (1) or write-through (0).
- `WRITE_ALLOC` picks whether a store that misses brings its line into the cache (1) or only updates memory (0).

The memory side uses one request/acknowledge handshake. It carries three kinds of transfer: a line fill, a full-line writeback, and a byte-masked store.

A request is held until `cpu_ready` is high on a rising edge. `cpu_hit` marks whether that request was served without a miss. The controller runs four states:
- `ST_IDLE`: tag lookup and hit service.
- `ST_EVICT`: writeback of a dirty victim.
- `ST_FILL`: line fetch.
- `ST_WTHRU`: store forwarded to memory.

The transitions are:
- `ST_IDLE` to `ST_EVICT` on an allocating miss whose victim is valid and dirty.
- `ST_IDLE` to `ST_FILL` on an allocating miss with a clean or invalid victim.
- `ST_IDLE` to `ST_WTHRU` on a write-through store hit, or on a store miss without allocation.
- `ST_EVICT` to `ST_FILL` on acknowledge.
- `ST_FILL` to `ST_IDLE` on acknowledge. The pending access is then replayed as a hit.
- `ST_WTHRU` to `ST_IDLE` on acknowledge. This completes the access.

Top module: `dm_cache`

## Requirements
- R1: The address is split into tag (bits 31:10), line index (bits 9:5) and byte offset (bits 4:0), and the word within a line is bits 4:2. Two addresses 1 KB apart compete for one line. Another word of a line that is present hits.
- R2: A load that hits completes in its request cycle, with `cpu_ready` and `cpu_hit` high, and causes no memory transfer.
- R3: A store changes only the bytes whose enable is set: enable bit k selects byte k of the addressed word, and byte k holds data bits 8k+7:8k. The other bytes of the line keep their values.
- R4: In write-back mode a store hit updates only the cache line, marks it dirty, and causes no memory write.
- R5: In write-back mode, evicting a dirty line writes the whole line to memory (all 32 byte enables) before the fill request for the new line is made. A clean victim is dropped with no memory write.
- R6: In write-through mode every store is sent to memory with its byte mask placed at the word's position. Lines are never dirty, and a load miss never writes memory.
- R7: With write allocation, a store miss fetches the line and then performs the store as a hit. The store is reported as a miss.
- R8: Without write allocation, a store miss updates memory only and leaves the cache unchanged, so a later load of that line misses.
- R9: While a memory transfer is outstanding, `cpu_ready` stays low, and `mem_req`, `mem_addr` and `mem_we` hold until `mem_ack`.
- R10: After reset every line is invalid, `cpu_ready` is low and no memory request is made.
- R11: From empty, the store/store/load/store/store sequence on byte addresses 100, 100, 200, 200, 100 gives 1 hit without write allocation and 3 hits with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables within the addressed word |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at the next rising edge |
| cpu_hit | output | 1 | Completing access was served without a miss |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer, 0 = line fill |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_be | output | 32 | Byte mask of a write transfer |
| mem_wdata | output | 256 | Write data for the line |
| mem_ack | input | 1 | Transfer done; fill data valid |
| mem_rdata | input | 256 | Fill data for the line |

## Verification
The bench builds four copies of the block, one for each combination of `WRITE_BACK` and `WRITE_ALLOC`, over a 4 KB address window. With only four possible tags per line, conflict evictions happen constantly. Write-back copies therefore reach both dirty-victim writebacks and clean-victim drops. Non-allocating copies reach store misses that bypass the cache, and write-through copies show load misses that must not write memory. Each copy checks per access the hit flag, the load data, and the number of memory writes and fills, then compares the whole memory window at the end.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int NUM_LINES  = 32,
    parameter int TAG_W      = 22,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set,
    output logic             lk_valid,
    output logic             lk_dirty,
    output logic [TAG_W-1:0] lk_tag
);
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) tag_q[idx] <= fill_tag;
    end

    assign lk_valid = valid_q[idx];
    assign lk_dirty = dirty_q[idx];
    assign lk_tag   = tag_q[idx];

    if (!WRITE_BACK) begin : g_wt_chk
        // R6: write-through lines never become dirty
        a_r6_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q == '0);
    end
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int NUM_LINES  = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  line_we,
    input  logic [LINE_W-1:0]     line_wdata,
    input  logic                  word_we,
    input  logic [WSEL_W-1:0]     word_sel,
    input  logic [WORD_BYTES-1:0] word_be,
    input  logic [WORD_W-1:0]     word_wdata,
    output logic [LINE_W-1:0]     line_rdata
);
    logic [LINE_W-1:0]     lines_q [NUM_LINES];
    logic [LINE_BYTES-1:0] lane_we;
    logic [LINE_W-1:0]     lane_data;

    for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
        assign lane_we[j] = line_we |
            (word_we & (word_sel == WSEL_W'(j / WORD_BYTES)) & word_be[j % WORD_BYTES]);
        assign lane_data[j*8 +: 8] = line_we ? line_wdata[j*8 +: 8]
                                             : word_wdata[(j % WORD_BYTES)*8 +: 8];
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < LINE_BYTES; j++) begin
            if (lane_we[j]) lines_q[idx][j*8 +: 8] <= lane_data[j*8 +: 8];
        end
    end

    assign line_rdata = lines_q[idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_LINES   = 32,
    parameter int LINE_BYTES  = 32,
    parameter int WORD_BYTES  = 4,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(NUM_LINES),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
    localparam int WOFF_W     = $clog2(WORD_BYTES),
    localparam int WSEL_W     = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_BYTES-1:0] cpu_be,
    input  logic                  lk_valid,
    input  logic                  lk_dirty,
    input  logic [TAG_W-1:0]      lk_tag,
    input  logic                  mem_ack,
    output logic                  cpu_ready,
    output logic                  cpu_hit,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic                  wr_from_cpu,
    output logic                  tag_fill_we,
    output logic                  dirty_set,
    output logic                  line_we,
    output logic                  word_we
);
    dmc_state_e state_q, state_d;
    logic       miss_q, miss_d;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] wsel;
    logic              lookup_hit;

    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx    = cpu_addr[OFF_W +: IDX_W];
    assign wsel       = cpu_addr[WOFF_W +: WSEL_W];
    assign lookup_hit = lk_valid && (lk_tag == req_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
        end
    end

    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        if (cpu_we && !WRITE_BACK) state_d = ST_WTHRU;
                        else                       miss_d  = 1'b0;
                    end else begin
                        miss_d = 1'b1;
                        if (cpu_we && !WRITE_ALLOC)      state_d = ST_WTHRU;
                        else if (lk_valid && lk_dirty)   state_d = ST_EVICT;
                        else                             state_d = ST_FILL;
                    end
                end
            end
            ST_EVICT: if (mem_ack) state_d = ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_IDLE;
            ST_WTHRU: begin
                if (mem_ack) begin
                    state_d = ST_IDLE;
                    miss_d  = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_be      = '0;
        wr_from_cpu = 1'b0;
        tag_fill_we = 1'b0;
        dirty_set   = 1'b0;
        line_we     = 1'b0;
        word_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && lookup_hit) begin
                    if (!cpu_we) begin
                        cpu_ready = 1'b1;
                    end else begin
                        word_we = 1'b1;
                        if (WRITE_BACK) begin
                            cpu_ready = 1'b1;
                            dirty_set = 1'b1;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_be   = '1;
                mem_addr = {lk_tag, req_idx, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_idx, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    line_we     = 1'b1;
                    tag_fill_we = 1'b1;
                end
            end
            ST_WTHRU: begin
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                wr_from_cpu = 1'b1;
                mem_addr    = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                mem_be      = LINE_BYTES'(cpu_be) << (WORD_BYTES * int'(wsel));
                cpu_ready   = mem_ack;
            end
            default: ;
        endcase
    end

    assign cpu_hit = cpu_ready && !miss_q;

    // R9: an outstanding transfer holds its request, address and direction
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: the processor is stalled while memory is busy
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> !cpu_ready);

    // R2: a load hit completes with no memory traffic
    a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_hit && !cpu_we) |-> !mem_req);

    if (WRITE_BACK) begin : g_wb_chk
        // R5: an acknowledged writeback is followed directly by a fill request
        a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we && (&mem_be) && mem_ack) |=> (mem_req && !mem_we));
        // R4: in write-back mode a cached write reaches memory only as a whole line
        a_r4_wb_full_line: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we && !wr_from_cpu) |-> (&mem_be));
    end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
    parameter int ADDR_W      = 32,
    parameter int NUM_LINES   = 32,
    parameter int LINE_BYTES  = 32,
    parameter int WORD_BYTES  = 4,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    localparam int LINE_W     = LINE_BYTES * 8,
    localparam int WORD_W     = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_BYTES-1:0] cpu_be,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic                  cpu_hit,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic                  mem_ack,
    input  logic [LINE_W-1:0]     mem_rdata
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WOFF_W = $clog2(WORD_BYTES);
    localparam int WSEL_W = $clog2(LINE_BYTES / WORD_BYTES);
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;

    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic              lk_valid, lk_dirty;
    logic [TAG_W-1:0]  lk_tag;
    logic              tag_fill_we, dirty_set, line_we, word_we, wr_from_cpu;
    logic [LINE_W-1:0] line_rdata;

    assign idx  = cpu_addr[OFF_W +: IDX_W];
    assign wsel = cpu_addr[WOFF_W +: WSEL_W];

    dmc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .WRITE_BACK(WRITE_BACK)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .fill_we  (tag_fill_we),
        .fill_tag (cpu_addr[ADDR_W-1 -: TAG_W]),
        .dirty_set(dirty_set),
        .lk_valid (lk_valid),
        .lk_dirty (lk_dirty),
        .lk_tag   (lk_tag)
    );

    dmc_data_store #(
        .NUM_LINES (NUM_LINES),
        .LINE_BYTES(LINE_BYTES),
        .WORD_BYTES(WORD_BYTES)
    ) u_data (
        .clk       (clk),
        .idx       (idx),
        .line_we   (line_we),
        .line_wdata(mem_rdata),
        .word_we   (word_we),
        .word_sel  (wsel),
        .word_be   (cpu_be),
        .word_wdata(cpu_wdata),
        .line_rdata(line_rdata)
    );

    dmc_ctrl #(
        .ADDR_W     (ADDR_W),
        .NUM_LINES  (NUM_LINES),
        .LINE_BYTES (LINE_BYTES),
        .WORD_BYTES (WORD_BYTES),
        .WRITE_BACK (WRITE_BACK),
        .WRITE_ALLOC(WRITE_ALLOC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_be     (cpu_be),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .lk_tag     (lk_tag),
        .mem_ack    (mem_ack),
        .cpu_ready  (cpu_ready),
        .cpu_hit    (cpu_hit),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .wr_from_cpu(wr_from_cpu),
        .tag_fill_we(tag_fill_we),
        .dirty_set  (dirty_set),
        .line_we    (line_we),
        .word_we    (word_we)
    );

    assign cpu_rdata = line_rdata[int'(wsel)*WORD_W +: WORD_W];
    assign mem_wdata = wr_from_cpu ? {WORDS{cpu_wdata}} : line_rdata;
endmodule

// File: tb/dm_cache_harness.sv
module dm_cache_harness #(
    parameter bit          WB     = 1'b1,
    parameter bit          WA     = 1'b1,
    parameter int unsigned SEED   = 1,
    parameter int          N_RAND = 300
) (
    input  logic clk,
    output int   n_chk,
    output int   n_fail,
    output logic done
);
    localparam int MEM_BYTES = 4096;
    localparam int NL        = 32;

    logic         rst_n;
    logic         cpu_req, cpu_we, cpu_ready, cpu_hit;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic [3:0]   cpu_be;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_be;
    logic [255:0] mem_wdata, mem_rdata;

    dm_cache #(.WRITE_BACK(WB), .WRITE_ALLOC(WA)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'(i * 7 + 3);
    endfunction

    // memory model driven by the design's transfers
    logic [7:0] bmem [MEM_BYTES];
    int lat_cnt, n_mem_wr, n_mem_fill;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack    <= 1'b0;
            mem_rdata  <= '0;
            lat_cnt    <= 0;
            n_mem_wr   <= 0;
            n_mem_fill <= 0;
            for (int i = 0; i < MEM_BYTES; i++) bmem[i] <= init_byte(i);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= 2) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int j = 0; j < 32; j++)
                        if (mem_be[j]) bmem[int'(mem_addr[11:0]) + j] <= mem_wdata[j*8 +: 8];
                    n_mem_wr <= n_mem_wr + 1;
                end else begin
                    for (int j = 0; j < 32; j++)
                        mem_rdata[j*8 +: 8] <= bmem[int'(mem_addr[11:0]) + j];
                    n_mem_fill <= n_mem_fill + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // reference model
    logic [7:0]   rmem [MEM_BYTES];
    int           r_tag [NL];
    bit           r_val [NL];
    bit           r_dirty [NL];
    logic [255:0] r_data [NL];

    task automatic ref_access(input bit we, input logic [31:0] a, input logic [3:0] be,
                              input logic [31:0] wd, output bit hit, output logic [31:0] rd,
                              output int wr, output int fl);
        int idx = int'(a[9:5]);
        int tg  = int'(a[31:10]);
        int ws  = int'(a[4:2]);
        int base = int'({a[11:5], 5'b0});
        hit = r_val[idx] && (r_tag[idx] == tg);
        wr = 0; fl = 0; rd = '0;
        if (!hit && (!we || WA)) begin
            if (r_val[idx] && r_dirty[idx]) begin
                for (int j = 0; j < 32; j++)
                    rmem[(r_tag[idx] << 10) + (idx << 5) + j] = r_data[idx][j*8 +: 8];
                wr++;
            end
            for (int j = 0; j < 32; j++) r_data[idx][j*8 +: 8] = rmem[base + j];
            r_val[idx] = 1'b1; r_tag[idx] = tg; r_dirty[idx] = 1'b0;
            fl++;
        end
        if (!we) begin
            rd = r_data[idx][ws*32 +: 32];
        end else if (r_val[idx] && r_tag[idx] == tg) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) r_data[idx][(ws*4 + b)*8 +: 8] = wd[b*8 +: 8];
            if (WB) r_dirty[idx] = 1'b1;
            else begin
                for (int b = 0; b < 4; b++) if (be[b]) rmem[base + ws*4 + b] = wd[b*8 +: 8];
                wr++;
            end
        end else begin
            for (int b = 0; b < 4; b++) if (be[b]) rmem[base + ws*4 + b] = wd[b*8 +: 8];
            wr++;
        end
    endtask

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (WB=%0d WA=%0d): actual %0h expected %0h", rq, WB, WA, act, exp);
        end
    endtask

    task automatic do_access(input bit we, input logic [31:0] a, input logic [3:0] be,
                             input logic [31:0] wd, input string rq, output bit got_hit);
        bit eh; logic [31:0] er; int ew, ef, w0, f0;
        bit first_rdy, first;
        logic [31:0] got_rd;
        ref_access(we, a, be, wd, eh, er, ew, ef);
        @(negedge clk);
        w0 = n_mem_wr; f0 = n_mem_fill;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        first = 1'b1; first_rdy = 1'b0;
        forever begin
            #1;
            if (first) first_rdy = cpu_ready;
            first = 1'b0;
            if (cpu_ready) break;
            @(negedge clk);
        end
        got_hit = cpu_hit;
        got_rd  = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        chk(got_hit == eh, {rq, " hit flag"}, 32'(got_hit), 32'(eh));
        if (!we) chk(got_rd == er, {rq, " load data (R3)"}, got_rd, er);
        chk(first_rdy == (eh && (!we || WB)), "R9 ready timing", 32'(first_rdy), 32'(eh && (!we || WB)));
        chk((n_mem_wr - w0) == ew, (ew > 0 && WB) ? "R5 memory writes" : (WB ? "R4 memory writes" : "R6 memory writes"),
            32'(n_mem_wr - w0), 32'(ew));
        chk((n_mem_fill - f0) == ef, "R7 line fills", 32'(n_mem_fill - f0), 32'(ef));
    endtask

    initial begin
        bit h;
        int hits;
        int bad;
        logic [31:0] a;
        logic [3:0]  be;
        n_chk = 0; n_fail = 0; done = 1'b0;
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
        for (int i = 0; i < MEM_BYTES; i++) rmem[i] = init_byte(i);
        for (int i = 0; i < NL; i++) begin r_val[i] = 0; r_dirty[i] = 0; r_tag[i] = 0; r_data[i] = '0; end
        void'($urandom(SEED));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!cpu_ready && !mem_req, "R10 idle after reset", {cpu_ready, mem_req}, 32'h0);

        // R11: counted sequence from empty
        hits = 0;
        do_access(1, 32'd100, 4'hF, 32'hA1A1A1A1, "R11", h); hits += int'(h);
        do_access(1, 32'd100, 4'hF, 32'hB2B2B2B2, "R11", h); hits += int'(h);
        do_access(0, 32'd200, 4'hF, 32'h0,        "R11", h); hits += int'(h);
        do_access(1, 32'd200, 4'hF, 32'hC3C3C3C3, "R11", h); hits += int'(h);
        do_access(1, 32'd100, 4'hF, 32'hD4D4D4D4, "R11", h); hits += int'(h);
        chk(hits == (WA ? 3 : 1), "R11 hit count", 32'(hits), WA ? 32'd3 : 32'd1);

        // R10: untouched line misses first time
        do_access(0, 32'h0000_0A40, 4'hF, 32'h0, "R10", h);
        // R1: other word of a present line hits; 1 KB apart conflicts
        do_access(0, 32'h0000_0A5C, 4'hF, 32'h0, "R1", h);
        chk(h == 1'b1, "R1 same line hit", 32'(h), 32'd1);
        do_access(0, 32'h0000_0E40, 4'hF, 32'h0, "R1", h);
        chk(h == 1'b0, "R1 conflict miss", 32'(h), 32'd0);
        // R3: halfword store on bytes 0-1, then single byte 3
        do_access(1, 32'h0000_0E44, 4'b0011, 32'h1234_5678, "R3", h);
        do_access(1, 32'h0000_0E44, 4'b1000, 32'h9A00_0000, "R3", h);
        do_access(0, 32'h0000_0E44, 4'hF, 32'h0, "R3", h);
        // R5: dirty victim then clean victim
        do_access(1, 32'h0000_0000, 4'hF, 32'h5555_AAAA, "R5", h);
        do_access(0, 32'h0000_0400, 4'hF, 32'h0, "R5", h);
        do_access(0, 32'h0000_0800, 4'hF, 32'h0, "R5", h);
        // R8 / R7: store miss then load of same line
        do_access(1, 32'h0000_0300, 4'hF, 32'h7777_8888, WA ? "R7" : "R8", h);
        do_access(0, 32'h0000_0304, 4'hF, 32'h0, WA ? "R7" : "R8", h);
        chk(h == WA, WA ? "R7 allocated line" : "R8 line not allocated", 32'(h), 32'(WA));
        // R6: load miss over a written-through line
        do_access(0, 32'h0000_0700, 4'hF, 32'h0, "R6", h);

        // R2: mixed random traffic
        for (int i = 0; i < N_RAND; i++) begin
            int kind;
            a = $urandom % MEM_BYTES;
            kind = $urandom % 3;
            if (kind == 0) be = 4'(1 << a[1:0]);
            else if (kind == 1) be = a[1] ? 4'b1100 : 4'b0011;
            else be = 4'hF;
            a[1:0] = 2'b00;
            do_access(1'($urandom % 2), a, be, $urandom, "R2", h);
        end

        // final memory image (R4 for write-back, R6 for write-through)
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < MEM_BYTES; i++) if (bmem[i] !== rmem[i]) bad++;
        chk(bad == 0, WB ? "R4 final memory image" : "R6 final memory image", 32'(bad), 32'd0);
        done = 1'b1;
    end
endmodule

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int   c0, c1, c2, c3, f0, f1, f2, f3;
    logic d0, d1, d2, d3;

    dm_cache_harness #(.WB(1'b1), .WA(1'b1), .SEED(11)) h_wb_wa   (.clk(clk), .n_chk(c0), .n_fail(f0), .done(d0));
    dm_cache_harness #(.WB(1'b1), .WA(1'b0), .SEED(23)) h_wb_nwa  (.clk(clk), .n_chk(c1), .n_fail(f1), .done(d1));
    dm_cache_harness #(.WB(1'b0), .WA(1'b1), .SEED(37)) h_wt_wa   (.clk(clk), .n_chk(c2), .n_fail(f2), .done(d2));
    dm_cache_harness #(.WB(1'b0), .WA(1'b0), .SEED(41)) h_wt_nwa  (.clk(clk), .n_chk(c3), .n_fail(f3), .done(d3));

    initial begin
        int cycles = 0;
        int tot_c, tot_f;
        bit timed_out = 1'b0;
        #1;
        while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1 && d3 === 1'b1)) begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                timed_out = 1'b1;
                break;
            end
        end
        tot_c = c0 + c1 + c2 + c3;
        tot_f = f0 + f1 + f2 + f3;
        if (timed_out) begin
            tot_c++;
            tot_f++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", tot_c, tot_f);
        $finish;
    end
endmodule